// File: doc/BRIEF.md
# Register Window Spill/Fill Engine

This block replaces the software trap handler that a windowed-register processor would otherwise run when a call runs out of free windows or a return finds its caller's window already evicted. The core raises a request with the current window pointer, the invalid-window mask and a flag that tells a spill from a fill. The engine then works out the target window and reads that window's stack pointer, which is out register 6 of that window. It moves the sixteen local and in registers between the register file and the 64-byte save area at that pointer, as eight doubleword beats. Last, it hands back the invalid-window mask rotated by one place.

A spill works on the window one step in the call direction (current pointer minus one, modulo the window count), which the mask marks as invalid. Data goes from the registers to memory as stores. A fill works on the window the return was trying to enter (current pointer plus one, modulo the window count). Data comes from memory into the registers as loads. While the beats run, the engine raises an output that tells the core to suppress window-invalid checking. The rotated mask is published only after the eighth beat has completed.

Both the request input and the memory port are valid/ready. A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the engine is idle again, so a second request simply waits. On the memory side, the engine holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready` is seen high at a clock edge. `mem_ready` may stay low for any number of cycles. For a load, `mem_rdata` is taken in the same cycle as the handshake.

Top module: `wsf_engine`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is 1. It drops to 0 the cycle after a request is accepted and stays 0 until the engine returns to idle, so a request presented while busy is not taken.
- R2: In the cycle after acceptance, the engine presents window `req_cwp-1` (spill) or `req_cwp+1` (fill), modulo the window count, on `rf_win` and register index 14 on `rf_idx`. It takes the upper 32 bits of `rf_rdata` (the even register of the pair) as the save-area base.
- R3: Exactly eight memory beats follow, to byte addresses base+0, +8, … +56 in that order. On beat k, `rf_idx` is 16+2k: locals 0/1 through 6/7, then ins 0/1 through 6/7.
- R4: On a spill every beat has `mem_we`=1 and `mem_wdata` equal to `rf_rdata`, which is {even register, odd register}: even in bits 63:32, odd in bits 31:0.
- R5: On a fill every beat has `mem_we`=0. In the handshake cycle `rf_we` is 1 and `rf_wdata` equals `mem_rdata`, which writes the even register from bits 63:32 and the odd register from bits 31:0. `rf_we` is 0 at every other time.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle keeps `mem_valid` at 1 with `mem_addr`, `mem_we` and `rf_idx` unchanged.
- R7: After a spill, `wim_new` is the accepted mask rotated right by one bit, with bit 0 moving into the top bit.
- R8: After a fill, `wim_new` is the accepted mask rotated left by one bit, with the top bit moving into bit 0.
- R9: `wim_we` pulses for one cycle, in the cycle after the eighth handshake. `done` pulses for one cycle in the cycle after that, and the engine is idle one cycle later.
- R10: `chk_off` is 1 from the cycle after acceptance through the last memory beat, and 0 while idle and while `wim_we` is 1.
- R11: Asynchronous active-low reset, which may come at any point of an operation, forces the idle state: `req_ready`=1 and `mem_valid`, `rf_we`, `wim_we`, `done` and `chk_off` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Spill/fill request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_fill | input | 1 | 1 = fill (underflow), 0 = spill (overflow) |
| req_cwp | input | CW | Current window pointer at the request |
| req_wim | input | NWIN | Invalid-window mask at the request |
| chk_off | output | 1 | Suppress window-invalid checking |
| wim_we | output | 1 | Write strobe for the new mask |
| wim_new | output | NWIN | Rotated invalid-window mask |
| done | output | 1 | Operation complete pulse |
| rf_win | output | CW | Window addressed in the register file |
| rf_idx | output | 5 | Even register index of the pair accessed |
| rf_rdata | input | 64 | Pair read data {even, odd} |
| rf_we | output | 1 | Pair write enable |
| rf_wdata | output | 64 | Pair write data {even, odd} |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory accepts or completes the beat |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | AW | Byte address of the doubleword |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid in the handshake cycle |

## Verification
The assertions assume that `rf_rdata` is a combinational read of the pair named by `rf_win`/`rf_idx`, and that the core raises a request only when the mask really marks the target window as invalid. The rotation checks depend only on the mask that was latched, but the beat-count and back-pressure checks assume `mem_ready` is meaningful only while `mem_valid` is high. The stimulus keeps to this. Its register-file model answers reads in the same cycle. Each table entry pairs a pointer with a mask whose single set bit is the target window, and this includes the wrap at window 0 and at the top window. `mem_ready` is driven high only when a beat is offered. While the engine is busy, the bench offers conflicting requests, but it drops them before the engine goes idle again.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_XFER = 3'd2,
    S_WIM  = 3'd3,
    S_DONE = 3'd4
  } wsf_state_e;

  localparam int unsigned REG_IDX_W  = 5;
  localparam int unsigned SP_IDX     = 14;
  localparam int unsigned PAIR_BASE  = 16;
  localparam int unsigned BEATS      = 8;
  localparam int unsigned BEAT_W     = $clog2(BEATS);
  localparam int unsigned BEAT_BYTES = 8;
  localparam int unsigned BYTE_SH    = $clog2(BEAT_BYTES);
endpackage

// File: rtl/wsf_ctrl.sv
module wsf_ctrl
  import wsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              mem_ready,
  output wsf_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              accept,
  output logic              beat_hs
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  assign accept  = (state == S_IDLE) && req_valid;
  assign beat_hs = (state == S_XFER) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      beat  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) state <= S_ADDR;
        S_ADDR: begin
          state <= S_XFER;
          beat  <= '0;
        end
        S_XFER: if (mem_ready) begin
          if (beat == LAST_BEAT) state <= S_WIM;
          else                   beat  <= beat + 1'b1;
        end
        S_WIM:  state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsf_target.sv
module wsf_target
  import wsf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned AW   = 32,
  localparam int unsigned CW  = $clog2(NWIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 req_fill,
  input  logic [CW-1:0]        req_cwp,
  input  logic [NWIN-1:0]      req_wim,
  input  wsf_state_e           state,
  input  logic [BEAT_W-1:0]    beat,
  input  logic [63:0]          rf_rdata,
  output logic                 fill_q,
  output logic [NWIN-1:0]      wim_q,
  output logic [CW-1:0]        win_q,
  output logic [REG_IDX_W-1:0] idx,
  output logic [AW-1:0]        addr
);
  localparam logic [CW-1:0] TOP_WIN = CW'(NWIN - 1);

  logic [CW-1:0] tgt;
  logic [AW-1:0] base_q;

  always_comb begin
    if (req_fill) tgt = (req_cwp == TOP_WIN) ? '0 : req_cwp + 1'b1;
    else          tgt = (req_cwp == '0) ? TOP_WIN : req_cwp - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      wim_q  <= '0;
      win_q  <= '0;
      base_q <= '0;
    end else begin
      if (accept) begin
        fill_q <= req_fill;
        wim_q  <= req_wim;
        win_q  <= tgt;
      end
      if (state == S_ADDR) base_q <= AW'(rf_rdata[63:32]);
    end
  end

  always_comb begin
    if (state == S_XFER)
      idx = REG_IDX_W'(PAIR_BASE) + REG_IDX_W'({beat, 1'b0});
    else
      idx = REG_IDX_W'(SP_IDX);
    addr = base_q + AW'({beat, {BYTE_SH{1'b0}}});
  end
endmodule

// File: rtl/wsf_wim_rot.sv
module wsf_wim_rot #(
  parameter int unsigned NWIN = 8
) (
  input  logic            to_left,
  input  logic [NWIN-1:0] wim_in,
  output logic [NWIN-1:0] wim_out
);
  logic [NWIN-1:0] rot_r;
  logic [NWIN-1:0] rot_l;

  for (genvar i = 0; i < NWIN; i++) begin : g_bit
    assign rot_r[i] = wim_in[(i + 1) % NWIN];
    assign rot_l[i] = wim_in[(i + NWIN - 1) % NWIN];
  end

  assign wim_out = to_left ? rot_l : rot_r;
endmodule

// File: rtl/wsf_engine.sv
module wsf_engine
  import wsf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned AW   = 32,
  localparam int unsigned CW  = $clog2(NWIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_fill,
  input  logic [CW-1:0]        req_cwp,
  input  logic [NWIN-1:0]      req_wim,
  output logic                 chk_off,
  output logic                 wim_we,
  output logic [NWIN-1:0]      wim_new,
  output logic                 done,
  output logic [CW-1:0]        rf_win,
  output logic [REG_IDX_W-1:0] rf_idx,
  input  logic [63:0]          rf_rdata,
  output logic                 rf_we,
  output logic [63:0]          rf_wdata,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [63:0]          mem_wdata,
  input  logic [63:0]          mem_rdata
);
  wsf_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              accept;
  logic              beat_hs;
  logic              fill_q;
  logic [NWIN-1:0]   wim_q;

  wsf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_ready (mem_ready),
    .state     (state),
    .beat      (beat),
    .accept    (accept),
    .beat_hs   (beat_hs)
  );

  wsf_target #(.NWIN(NWIN), .AW(AW)) u_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_fill (req_fill),
    .req_cwp  (req_cwp),
    .req_wim  (req_wim),
    .state    (state),
    .beat     (beat),
    .rf_rdata (rf_rdata),
    .fill_q   (fill_q),
    .wim_q    (wim_q),
    .win_q    (rf_win),
    .idx      (rf_idx),
    .addr     (mem_addr)
  );

  wsf_wim_rot #(.NWIN(NWIN)) u_rot (
    .to_left (fill_q),
    .wim_in  (wim_q),
    .wim_out (wim_new)
  );

  assign req_ready = (state == S_IDLE);
  assign mem_valid = (state == S_XFER);
  assign mem_we    = !fill_q;
  assign mem_wdata = rf_rdata;
  assign rf_we     = beat_hs && fill_q;
  assign rf_wdata  = mem_rdata;
  assign chk_off   = (state == S_ADDR) || (state == S_XFER);
  assign wim_we    = (state == S_WIM);
  assign done      = (state == S_DONE);
endmodule

// File: rtl/wsf_engine_checks.sv
module wsf_engine_checks #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned AW   = 32,
  localparam int unsigned CW  = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_fill,
  input logic [NWIN-1:0] req_wim,
  input logic            chk_off,
  input logic            wim_we,
  input logic [NWIN-1:0] wim_new,
  input logic            done,
  input logic [4:0]      rf_idx,
  input logic            rf_we,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr
);
  logic [3:0]      hs_cnt;
  logic            seen_fill;
  logic [NWIN-1:0] seen_wim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt    <= '0;
      seen_fill <= 1'b0;
      seen_wim  <= '0;
    end else if (req_valid && req_ready) begin
      hs_cnt    <= '0;
      seen_fill <= req_fill;
      seen_wim  <= req_wim;
    end else if (mem_valid && mem_ready) begin
      hs_cnt <= hs_cnt + 1'b1;
    end
  end

  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_eight_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wim_we |-> (hs_cnt == 4'd8));

  p_fill_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_valid && mem_ready && !mem_we));

  p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(rf_idx)));

  p_rot_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wim_we && !seen_fill) |-> (wim_new == {seen_wim[0], seen_wim[NWIN-1:1]}));

  p_rot_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wim_we && seen_fill) |-> (wim_new == {seen_wim[NWIN-2:0], seen_wim[NWIN-1]}));

  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wim_we |=> (done && !wim_we));

  p_check_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || wim_we) |-> !chk_off);
endmodule

bind wsf_engine wsf_engine_checks #(.NWIN(NWIN), .AW(AW)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_fill  (req_fill),
  .req_wim   (req_wim),
  .chk_off   (chk_off),
  .wim_we    (wim_we),
  .wim_new   (wim_new),
  .done      (done),
  .rf_idx    (rf_idx),
  .rf_we     (rf_we),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/wsf_engine_tb.sv
module wsf_engine_tb_top;
  localparam int NW = 8;
  localparam int CW = 3;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_fill = 1'b0;
  logic [CW-1:0] req_cwp = '0;
  logic [NW-1:0] req_wim = '0;
  logic          chk_off, wim_we, done;
  logic [NW-1:0] wim_new;
  logic [CW-1:0] rf_win;
  logic [4:0]    rf_idx;
  logic [63:0]   rf_rdata;
  logic          rf_we;
  logic [63:0]   rf_wdata;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic [63:0]   mem_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  logic [31:0] regs [0:NW-1][0:31];

  assign rf_rdata = {regs[rf_win][rf_idx], regs[rf_win][rf_idx | 5'd1]};

  always @(posedge clk) begin
    if (rf_we) begin
      regs[rf_win][rf_idx]        <= rf_wdata[63:32];
      regs[rf_win][rf_idx | 5'd1] <= rf_wdata[31:0];
    end
  end

  wsf_engine #(.NWIN(NW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_fill(req_fill),
    .req_cwp(req_cwp), .req_wim(req_wim),
    .chk_off(chk_off), .wim_we(wim_we), .wim_new(wim_new), .done(done),
    .rf_win(rf_win), .rf_idx(rf_idx), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // {fill, cwp, wim, stall, expected wim}
  localparam logic [21:0] VEC [0:5] = '{
    {1'b0, 3'd3, 8'h04, 2'd0, 8'h02},
    {1'b1, 3'd5, 8'h40, 2'd1, 8'h80},
    {1'b0, 3'd0, 8'h80, 2'd2, 8'h40},
    {1'b1, 3'd7, 8'h01, 2'd3, 8'h02},
    {1'b0, 3'd1, 8'h01, 2'd1, 8'h80},
    {1'b1, 3'd6, 8'h80, 2'd0, 8'h01}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] fill_pat(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  task automatic do_op(input bit fill, input int cwp, input logic [NW-1:0] wim,
                       input int stall, input logic [NW-1:0] exp_wim);
    int tgt;
    logic [31:0] base;
    tgt  = fill ? (cwp + 1) % NW : (cwp + NW - 1) % NW;
    base = regs[tgt][14];
    @(negedge clk);
    chk("R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_fill = fill; req_cwp = CW'(cwp); req_wim = wim;
    @(negedge clk);
    if (stall >= 2) begin
      req_fill = ~fill; req_cwp = CW'(cwp ^ 3); req_wim = ~wim;
    end else begin
      req_valid = 1'b0;
    end
    chk("R1 ready low while busy", req_ready, 0);
    chk("R10 check off in address phase", chk_off, 1);
    chk("R2 target window", rf_win, tgt);
    chk("R2 stack pointer index", rf_idx, 14);
    @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < stall; s++) begin
        chk("R6 valid held under stall", mem_valid, 1);
        chk("R6 address held under stall", mem_addr, base + 32'(8 * b));
        chk("R1 ready low during beats", req_ready, 0);
        @(negedge clk);
      end
      chk("R3 beat valid", mem_valid, 1);
      chk("R3 beat address", mem_addr, base + 32'(8 * b));
      chk("R3 pair index", rf_idx, 16 + 2 * b);
      chk("R10 check off during beats", chk_off, 1);
      if (!fill) begin
        chk("R4 store direction", mem_we, 1);
        chk("R4 store data", mem_wdata, {regs[tgt][16 + 2 * b], regs[tgt][17 + 2 * b]});
        chk("R5 no register write on spill", rf_we, 0);
      end else begin
        chk("R5 load direction", mem_we, 0);
        mem_rdata = fill_pat(base + 32'(8 * b));
      end
      mem_ready = 1'b1;
      if (fill) begin
        #1;
        chk("R5 register write strobe", rf_we, 1);
      end
      @(negedge clk);
      mem_ready = 1'b0;
    end
    req_valid = 1'b0;
    chk("R9 mask strobe", wim_we, 1);
    chk(fill ? "R8 rotate left" : "R7 rotate right", wim_new, exp_wim);
    chk("R10 check released at mask write", chk_off, 0);
    chk("R9 done not yet", done, 0);
    chk("R3 no ninth beat", mem_valid, 0);
    @(negedge clk);
    chk("R9 done pulse", done, 1);
    chk("R9 mask strobe single", wim_we, 0);
    @(negedge clk);
    chk("R9 idle after done", req_ready, 1);
    chk("R9 done single", done, 0);
    if (fill) begin
      for (int b = 0; b < 8; b++) begin
        chk("R5 even register filled", regs[tgt][16 + 2 * b], fill_pat(base + 32'(8 * b)) >> 32);
        chk("R5 odd register filled", regs[tgt][17 + 2 * b], fill_pat(base + 32'(8 * b)) & 64'hFFFF_FFFF);
      end
    end
  endtask

  initial begin
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 32; i++)
        regs[w][i] = (i == 14) ? 32'h0001_0000 + 32'(w) * 32'h100 : {8'(w), 8'(i), 16'hA5C3};
    repeat (2) @(negedge clk);
    chk("R11 reset ready", req_ready, 1);
    chk("R11 reset mem valid", mem_valid, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset chk off", chk_off, 0);
    chk("R11 reset mask strobe", wim_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);

    for (int v = 0; v < 6; v++)
      do_op(VEC[v][21], int'(VEC[v][20:18]), VEC[v][17:10], int'(VEC[v][9:8]), VEC[v][7:0]);

    // reset in the middle of a transfer
    @(negedge clk);
    req_valid = 1'b1; req_fill = 1'b0; req_cwp = 3'd4; req_wim = 8'h08;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 busy before reset", mem_valid, 1);
    rst_n = 1'b0;
    #1;
    chk("R11 mid-op reset ready", req_ready, 1);
    chk("R11 mid-op reset mem valid", mem_valid, 0);
    chk("R11 mid-op reset chk off", chk_off, 0);
    chk("R11 mid-op reset rf write", rf_we, 0);
    @(negedge clk);
    rst_n = 1'b1;
    do_op(1'b0, 4, 8'h08, 1, 8'h04);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule